// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a first-level data cache for the memory stage of an in-order pipeline. It holds lines of four 32-bit words in a configurable number of sets, two ways per set, with a valid and a dirty bit per way and a single least-recently-used bit per set. Tags and line data live in memories that are read and written synchronously, so they can map onto block RAM. The lookup is split across two clock edges: the array read happens on the edge that accepts a request, and the tag compare, load extraction and store merge happen in the following cycle. Hits therefore retire at one per cycle.

On a miss the cache does not drive any bus. It stalls the requester, raises a refill request carrying the line address of the missing line, and shows the chosen victim's line contents, its write-back address and whether it is dirty. An outside load/store unit writes the victim back if needed, fetches the missing line and hands it over through the fill port. The cache installs the line, rereads it, and then completes the held access as an ordinary hit. A store miss is therefore allocated first and merged afterwards.

Top module: `dcache2w`

## Requirements
- R1: A load that hits responds with rspValid high in the cycle after the request is accepted; rspRdata holds the addressed data right-aligned and zero-extended, with reqSize 0 = byte, 1 = halfword, 2 = word and the byte offset taken from reqAddr[1:0].
- R2: Back-to-back hits are accepted every cycle with stall low, and a load that directly follows a store to the same word returns the newly stored bytes.
- R3: A store that hits changes only the bytes it covers (one byte, the halfword selected by reqAddr[1], or the whole word) and marks the way dirty.
- R4: When an access misses, stall goes high in the cycle its result would have appeared; from the next cycle refillReq stays high with refillAddr equal to the line-aligned request address, and victimDirty, wbAddr and wbLine stay constant until the fill arrives.
- R5: A line presented with fillValid while refillReq is high is installed; the next cycle still stalls with no response and no refill request, and the cycle after that completes the held access, a store being merged into the freshly filled line.
- R6: The victim is way 0 if invalid, else way 1 if invalid, else the way named by the set's LRU bit.
- R7: After a hit or a fill in a way, the set's LRU bit names the other way.
- R8: victimDirty is high exactly when the victim way is valid and was written since it was filled; wbAddr is the victim's line address and wbLine its current contents.
- R9: After reset every way is invalid, and stall, rspValid and refillReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqAddr | input | ADDR_W | Byte address, naturally aligned |
| reqWdata | input | 32 | Store data, right-aligned |
| stall | output | 1 | Request not taken; hold inputs |
| rspValid | output | 1 | Access completed this cycle |
| rspRdata | output | 32 | Load result |
| refillReq | output | 1 | Miss pending, line needed |
| refillAddr | output | ADDR_W | Line address to fetch |
| victimDirty | output | 1 | Victim must be written back |
| wbAddr | output | ADDR_W | Victim line address |
| wbLine | output | LINE_W | Victim line data |
| fillValid | input | 1 | Fill line present |
| fillLine | input | LINE_W | Line to install |

## Verification
The assertions assume the requester keeps its request unchanged while stall is high, that accesses are naturally aligned, and that fillValid is only raised while refillReq is high; they also take for granted that the same tag never lands in both ways of a set, which the design guarantees only if fills follow misses. The bench drives every request through one task that holds its inputs across stalls, chooses sizes and offsets that are aligned, raises fillValid only after seeing refillReq, and sometimes waits several cycles before filling so the held victim outputs are observed over time.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_MISS   = 2'd1,
    ST_REPLAY = 2'd2
  } cacheState_t;

  typedef struct packed {
    logic stall;        // hold stage 1 and the requester
    logic commit;       // stage 1 hit retires this cycle
    logic latchVictim;  // capture victim way choice
    logic fillWrite;    // install fill line into victim way
    logic refillReq;    // miss outstanding
  } ctrlStrobes_t;
endpackage

// File: rtl/dcache_way_ram.sv
module dcache_way_ram #(
  parameter int TAG_W  = 25,
  parameter int LINE_W = 128,
  parameter int SETS   = 8
) (
  input  logic                     clk,
  input  logic [$clog2(SETS)-1:0]  rdIdx,
  input  logic                     wrEn,
  input  logic                     tagWrEn,
  input  logic [$clog2(SETS)-1:0]  wrIdx,
  input  logic [TAG_W-1:0]         wrTag,
  input  logic [LINE_W-1:0]        wrLine,
  output logic [TAG_W-1:0]         tagRd,
  output logic [LINE_W-1:0]        lineRd
);
  logic [TAG_W-1:0]  tagMem  [SETS];
  logic [LINE_W-1:0] lineMem [SETS];

  // read-before-write synchronous memories
  always_ff @(posedge clk) begin
    if (wrEn)    lineMem[wrIdx] <= wrLine;
    if (tagWrEn) tagMem[wrIdx]  <= wrTag;
    tagRd  <= tagMem[rdIdx];
    lineRd <= lineMem[rdIdx];
  end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         s1Valid,
  input  logic         s1Hit,
  input  logic         fillValid,
  output ctrlStrobes_t st
);
  cacheState_t state, stateNext;
  logic missNow;

  always_comb begin
    missNow        = (state == ST_LOOKUP) && s1Valid && !s1Hit;
    st.stall       = missNow || (state != ST_LOOKUP);
    st.commit      = (state == ST_LOOKUP) && s1Valid && s1Hit;
    st.latchVictim = missNow;
    st.fillWrite   = (state == ST_MISS) && fillValid;
    st.refillReq   = (state == ST_MISS);
    case (state)
      ST_LOOKUP: stateNext = missNow ? ST_MISS : ST_LOOKUP;
      ST_MISS:   stateNext = fillValid ? ST_REPLAY : ST_MISS;
      default:   stateNext = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOOKUP;
    else       state <= stateNext;
  end

  // R4
  refill_after_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && !s1Hit && !st.stall) or (s1Valid && !s1Hit && state == ST_LOOKUP) |=> st.refillReq);

  // R5
  replay_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.fillWrite |=> (st.stall && !st.commit && !st.refillReq));
endmodule

// File: rtl/dcache_dp.sv
module dcache_dp
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  localparam int LINE_W = WORDS * 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      st,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [LINE_W-1:0] fillLine,
  output logic              s1Valid,
  output logic              s1Hit,
  output logic [31:0]       rspRdata,
  output logic [ADDR_W-1:0] refillAddr,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [LINE_W-1:0] wbLine
);
  localparam int SET_W  = $clog2(SETS);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

  logic              s1Write;
  logic [1:0]        s1Size;
  logic [ADDR_W-1:0] s1Addr;
  logic [31:0]       s1Wdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Write <= 1'b0;
      s1Size  <= '0;
      s1Addr  <= '0;
      s1Wdata <= '0;
    end else if (!st.stall) begin
      s1Valid <= reqValid;
      s1Write <= reqWrite;
      s1Size  <= reqSize;
      s1Addr  <= reqAddr;
      s1Wdata <= reqWdata;
    end
  end

  logic [SET_W-1:0]  s1Idx, rdIdx;
  logic [TAG_W-1:0]  s1Tag;
  logic [WSEL_W-1:0] s1Word;
  logic [1:0]        s1Byte;
  assign s1Idx  = s1Addr[OFF_W +: SET_W];
  assign s1Tag  = s1Addr[ADDR_W-1 -: TAG_W];
  assign s1Word = s1Addr[2 +: WSEL_W];
  assign s1Byte = s1Addr[1:0];
  // while stalled keep rereading the pending set
  assign rdIdx  = st.stall ? s1Idx : reqAddr[OFF_W +: SET_W];

  logic [1:0]        validQ [SETS];
  logic [1:0]        dirtyQ [SETS];
  logic [SETS-1:0]   lruQ;
  logic              vicWay, vicPick, hitWay;
  logic [1:0]        hitVec, wayWe, fwdValid;
  logic [TAG_W-1:0]  tagRd    [2];
  logic [LINE_W-1:0] ramLine  [2];
  logic [LINE_W-1:0] wayLine  [2];
  logic [LINE_W-1:0] fwdLine  [2];
  logic [LINE_W-1:0] wrLine, hitLine, mergedLine;

  for (genvar g = 0; g < 2; g++) begin : gWay
    dcache_way_ram #(.TAG_W(TAG_W), .LINE_W(LINE_W), .SETS(SETS)) uRam (
      .clk    (clk),
      .rdIdx  (rdIdx),
      .wrEn   (wayWe[g]),
      .tagWrEn(st.fillWrite && (vicWay == 1'(g))),
      .wrIdx  (s1Idx),
      .wrTag  (s1Tag),
      .wrLine (wrLine),
      .tagRd  (tagRd[g]),
      .lineRd (ramLine[g])
    );
    assign wayWe[g]   = (st.commit && s1Write && (hitWay == 1'(g))) ||
                        (st.fillWrite && (vicWay == 1'(g)));
    assign hitVec[g]  = validQ[s1Idx][g] && (tagRd[g] == s1Tag);
    assign wayLine[g] = fwdValid[g] ? fwdLine[g] : ramLine[g];

    // bypass a write that collides with the read issued on the same edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fwdValid[g] <= 1'b0;
        fwdLine[g]  <= '0;
      end else begin
        fwdValid[g] <= wayWe[g] && (s1Idx == rdIdx);
        fwdLine[g]  <= wrLine;
      end
    end
  end

  assign hitWay  = hitVec[1];
  assign s1Hit   = |hitVec;
  assign hitLine = wayLine[hitWay];
  assign vicPick = !validQ[s1Idx][0] ? 1'b0 :
                   !validQ[s1Idx][1] ? 1'b1 : lruQ[s1Idx];

  logic [31:0] oldWord, alignedData, newWord, shifted;
  logic [3:0]  byteEn;
  always_comb begin
    oldWord = hitLine[{s1Word, 5'd0} +: 32];
    case (s1Size)
      2'd0:    begin byteEn = 4'b0001 << s1Byte;          alignedData = {4{s1Wdata[7:0]}};  end
      2'd1:    begin byteEn = 4'b0011 << {s1Byte[1], 1'b0}; alignedData = {2{s1Wdata[15:0]}}; end
      default: begin byteEn = 4'b1111;                     alignedData = s1Wdata;            end
    endcase
    for (int b = 0; b < 4; b++)
      newWord[8*b +: 8] = byteEn[b] ? alignedData[8*b +: 8] : oldWord[8*b +: 8];
    mergedLine = hitLine;
    mergedLine[{s1Word, 5'd0} +: 32] = newWord;
    shifted = oldWord >> {s1Byte, 3'd0};
    case (s1Size)
      2'd0:    rspRdata = {24'd0, shifted[7:0]};
      2'd1:    rspRdata = {16'd0, shifted[15:0]};
      default: rspRdata = oldWord;
    endcase
  end
  assign wrLine = st.fillWrite ? fillLine : mergedLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SETS; i++) begin
        validQ[i] <= '0;
        dirtyQ[i] <= '0;
      end
      lruQ   <= '0;
      vicWay <= 1'b0;
    end else begin
      if (st.latchVictim) vicWay <= vicPick;
      if (st.fillWrite) begin
        validQ[s1Idx][vicWay] <= 1'b1;
        dirtyQ[s1Idx][vicWay] <= 1'b0;
        lruQ[s1Idx]           <= ~vicWay;
      end
      if (st.commit) begin
        lruQ[s1Idx] <= ~hitWay;
        if (s1Write) dirtyQ[s1Idx][hitWay] <= 1'b1;
      end
    end
  end

  assign refillAddr  = {s1Addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wbAddr      = {tagRd[vicWay], s1Idx, {OFF_W{1'b0}}};
  assign wbLine      = wayLine[vicWay];
  assign victimDirty = validQ[s1Idx][vicWay] && dirtyQ[s1Idx][vicWay];

  // R1
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |-> $onehot0(hitVec));

  // R3
  dirty_on_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.commit && s1Write) |=> dirtyQ[$past(s1Idx)][$past(hitWay)]);

  // R7
  lru_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> (lruQ[$past(s1Idx)] == ~$past(hitWay)));

  // R4
  victim_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.refillReq && $past(st.refillReq)) |->
      ($stable(wbAddr) && $stable(wbLine) && $stable(victimDirty)));

  // R5
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.fillWrite |=> (validQ[$past(s1Idx)][$past(vicWay)] && !dirtyQ[$past(s1Idx)][$past(vicWay)]));
endmodule

// File: rtl/dcache2w.sv
module dcache2w
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  localparam int LINE_W = WORDS * 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              stall,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              refillReq,
  output logic [ADDR_W-1:0] refillAddr,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [LINE_W-1:0] wbLine,
  input  logic              fillValid,
  input  logic [LINE_W-1:0] fillLine
);
  ctrlStrobes_t st;
  logic s1Valid, s1Hit;

  dcache_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .s1Valid  (s1Valid),
    .s1Hit    (s1Hit),
    .fillValid(fillValid),
    .st       (st)
  );

  dcache_dp #(.ADDR_W(ADDR_W), .SETS(SETS), .WORDS(WORDS)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .fillLine   (fillLine),
    .s1Valid    (s1Valid),
    .s1Hit      (s1Hit),
    .rspRdata   (rspRdata),
    .refillAddr (refillAddr),
    .victimDirty(victimDirty),
    .wbAddr     (wbAddr),
    .wbLine     (wbLine)
  );

  assign stall     = st.stall;
  assign rspValid  = st.commit;
  assign refillReq = st.refillReq;
endmodule

// File: tb/tb_dcache2w.sv
module tb_dcache2w;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]   reqSize = 2'd0;
  logic [31:0]  reqAddr = '0, reqWdata = '0;
  logic         stall, rspValid, refillReq, victimDirty;
  logic [31:0]  rspRdata, refillAddr, wbAddr;
  logic [127:0] wbLine;
  logic         fillValid = 1'b0;
  logic [127:0] fillLine = '0;

  always #5 clk = ~clk;

  dcache2w dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .stall(stall), .rspValid(rspValid), .rspRdata(rspRdata),
    .refillReq(refillReq), .refillAddr(refillAddr), .victimDirty(victimDirty),
    .wbAddr(wbAddr), .wbLine(wbLine), .fillValid(fillValid), .fillLine(fillLine)
  );

  int nChecks = 0, nBad = 0;
  logic [31:0] truth [logic [31:0]];
  int  mTag   [8][2];
  bit  mValid [8][2];
  bit  mDirty [8][2];
  bit  mLru   [8];

  task automatic chk(bit ok, string rq, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] rdTruth(logic [31:0] wa);
    if (truth.exists(wa)) return truth[wa];
    return (wa * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [127:0] lineOf(logic [31:0] a);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[32*w +: 32] = rdTruth({4'd0, a[31:4], 2'(w)});
    return l;
  endfunction

  task automatic doAccess(bit wr, logic [1:0] sz, logic [31:0] a, logic [31:0] d, int hold);
    int set, tag, hw, v;
    bit expDirty;
    logic [31:0] expWb, word, expData;
    logic [127:0] expLine;
    logic [3:0] be;
    logic [31:0] al;
    set = int'(a[6:4]); tag = int'(a[31:7]);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWdata = d;
    @(negedge clk);
    hw = -1;
    for (int w = 0; w < 2; w++) if (mValid[set][w] && mTag[set][w] == tag) hw = w;
    if (hw < 0) begin
      chk(stall && !rspValid, "R4 miss stalls", {stall, rspValid}, 2'b10);
      v = !mValid[set][0] ? 0 : !mValid[set][1] ? 1 : int'(mLru[set]);
      expDirty = mValid[set][v] && mDirty[set][v];
      expWb = {7'(mTag[set][v]) == 7'(mTag[set][v]) ? 25'(mTag[set][v]) : 25'd0, 3'(set), 4'd0};
      expLine = lineOf(expWb);
      @(negedge clk);
      chk(refillReq, "R4 refill request", refillReq, 1);
      chk(refillAddr == {a[31:4], 4'd0}, "R4 refill address", refillAddr, {a[31:4], 4'd0});
      chk(victimDirty == expDirty, "R8 victim dirty flag", victimDirty, expDirty);
      if (expDirty) begin
        chk(wbAddr == expWb, "R6 victim address", wbAddr, expWb);
        chk(wbLine == expLine, "R8 victim line", wbLine, expLine);
      end
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(refillReq && stall && !rspValid, "R4 refill held", refillReq, 1);
        if (expDirty) chk(wbAddr == expWb && wbLine == expLine, "R4 victim stable", wbLine, expLine);
      end
      fillValid = 1'b1; fillLine = lineOf(a);
      @(negedge clk);
      fillValid = 1'b0;
      chk(stall && !refillReq && !rspValid, "R5 replay cycle", {stall, refillReq, rspValid}, 3'b100);
      mValid[set][v] = 1'b1; mDirty[set][v] = 1'b0; mTag[set][v] = tag; mLru[set] = ~v[0];
      hw = v;
      @(negedge clk);
    end
    chk(rspValid && !stall, wr ? "R5 store completes" : "R1 load completes", {rspValid, stall}, 2'b10);
    word = rdTruth({2'd0, a[31:2]});
    if (!wr) begin
      expData = word >> {a[1:0], 3'd0};
      if (sz == 2'd0) expData = {24'd0, expData[7:0]};
      else if (sz == 2'd1) expData = {16'd0, expData[15:0]};
      chk(rspRdata == expData, "R1 R2 load data", rspRdata, expData);
    end else begin
      case (sz)
        2'd0: begin be = 4'b0001 << a[1:0]; al = {4{d[7:0]}}; end
        2'd1: begin be = 4'b0011 << {a[1], 1'b0}; al = {2{d[15:0]}}; end
        default: begin be = 4'hF; al = d; end
      endcase
      for (int b = 0; b < 4; b++) if (be[b]) word[8*b +: 8] = al[8*b +: 8];
      truth[{2'd0, a[31:2]}] = word;
      mDirty[set][hw] = 1'b1;
    end
    mLru[set] = ~hw[0];
  endtask

  task automatic idle();
    reqValid = 1'b0;
    @(negedge clk);
    chk(!rspValid && !stall, "R2 idle no response", rspValid, 0);
  endtask

  initial begin
    #2_000_000;
    nChecks++; nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 8; s++) begin
      mLru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin mValid[s][w] = 0; mDirty[s][w] = 0; mTag[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!stall && !rspValid && !refillReq, "R9 reset outputs", {stall, rspValid, refillReq}, 3'b000);

    // R9 / R6: first access misses into way 0
    doAccess(0, 2'd2, 32'h0000_0100, 0, 0);
    // R1 back-to-back hits at several sizes and offsets
    doAccess(0, 2'd2, 32'h0000_0104, 0, 0);
    doAccess(0, 2'd0, 32'h0000_0101, 0, 0);
    doAccess(0, 2'd0, 32'h0000_0103, 0, 0);
    doAccess(0, 2'd1, 32'h0000_0102, 0, 0);
    // R2 R3 store then immediate load of the same word
    doAccess(1, 2'd0, 32'h0000_0105, 32'h0000_00A7, 0);
    doAccess(0, 2'd2, 32'h0000_0104, 0, 0);
    doAccess(1, 2'd1, 32'h0000_0106, 32'h0000_BEEF, 0);
    doAccess(0, 2'd2, 32'h0000_0104, 0, 0);
    doAccess(1, 2'd2, 32'h0000_010C, 32'h1234_5678, 0);
    doAccess(0, 2'd1, 32'h0000_010E, 0, 0);
    idle();
    // R6 second line in set 0 goes to invalid way 1
    doAccess(0, 2'd2, 32'h0000_0180, 0, 0);
    doAccess(0, 2'd2, 32'h0000_0100, 0, 0);
    // R7 R8 clean eviction of way 1, then dirty eviction of way 0 with held fill
    doAccess(0, 2'd2, 32'h0000_0200, 0, 1);
    doAccess(0, 2'd2, 32'h0000_0280, 0, 3);
    // R5 store miss is allocated then merged
    doAccess(1, 2'd0, 32'h0000_0306, 32'h0000_005C, 2);
    doAccess(0, 2'd2, 32'h0000_0304, 0, 0);
    idle();
    // mixed traffic over four sets and four tags
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [1:0] sz;
      sz = 2'($urandom % 3);
      a = {23'd0, 2'($urandom), 3'($urandom % 4), 2'($urandom), 2'($urandom)};
      if (sz == 2'd1) a[0] = 1'b0;
      if (sz == 2'd2) a[1:0] = 2'b00;
      doAccess(bit'($urandom % 2), sz, a, $urandom, int'($urandom % 3));
      if (i % 37 == 0) idle();
    end
    idle();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule